// File: doc/BRIEF.md
# Synchronization Event Phase-Reset Gate

This block watches two synchronization event inputs and decides which clock-phase domains each event realigns. One input is an active-low link synchronization request, where a high-to-low transition counts as an event. The other is a system reference strobe, where a low-to-high transition counts as an event. For every event the block may emit a one-cycle reset pulse to the link-layer domain and a one-cycle reset pulse to the datapath domain. The link-layer domain is the serial link block together with the clock dividers. The datapath domain is the demodulator together with the test pattern generator.

Two configuration bits select the policy. With both bits clear, every event realigns both domains. The "keep link" bit protects the link-layer domain, so that events reach only the datapath. The "first only" bit gives a one-shot mode: the first event after the bit is set realigns both domains, and every later event realigns only the datapath. A status output shows whether that one-shot full realignment has already been used. Both event inputs are expected to be synchronous to the block clock already.

Top module: `psg_phase_reset_gate`

## Requirements
- R1: With both policy bits clear, an event on either input makes `link_rst_pulse` and `dp_rst_pulse` both high for exactly one cycle. The pulse appears in the cycle after the clock edge at which the event input is first seen at its active level.
- R2: `sync_n` makes an event only on a 1-to-0 transition, and `sysref` only on a 0-to-1 transition. Holding either input at its active level, or returning it to its idle level, produces no pulse.
- R3: With `cfg_keep_link`=1 and `cfg_first_only`=0, each event pulses `dp_rst_pulse` only, and `link_rst_pulse` stays 0.
- R4: With `cfg_first_only`=1 and the one-shot not yet used, the next event pulses both outputs. In the same cycle `oneshot_spent` becomes 1.
- R5: With `cfg_first_only`=1 and `oneshot_spent`=1, each event pulses `dp_rst_pulse` only.
- R6: While `cfg_first_only`=0, `oneshot_spent` reads 0 from the next cycle onward. Setting the bit again re-arms the one-shot, so the next event again pulses both outputs.
- R7: With both policy bits set, `link_rst_pulse` never pulses. An event in this state still uses up the one-shot and sets `oneshot_spent`.
- R8: Events on both inputs in the same cycle act as one event and produce one single-cycle pulse per output.
- R9: During reset and in the first cycle after it, all outputs are 0. An input level that is already active when reset is released produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Link synchronization request, active low, already synchronized |
| sysref | input | 1 | System reference strobe, active high, already synchronized |
| cfg_keep_link | input | 1 | 1 = events never reset the link-layer domain |
| cfg_first_only | input | 1 | 1 = one-shot mode: full realignment on the first event only |
| link_rst_pulse | output | 1 | One-cycle phase reset for the link block and clock dividers |
| dp_rst_pulse | output | 1 | One-cycle phase reset for the demodulator and test pattern generator |
| oneshot_spent | output | 1 | 1 = the one-shot full realignment has been used |

## Verification
All four combinations of the policy bits are swept. Under each combination the bench sends a run of three events from the request input alone, from the strobe alone, and from both inputs together. It compares each pulse against a small arithmetic model that tracks the one-shot state. The single-source runs separate the two edge polarities. The combined runs show that coincident events merge into one pulse. The three-event runs separate the first event from the later ones, so the one-shot decision and its re-arming, which the bench triggers by clearing the mode bit between combinations, are checked on every sweep. Separate stimuli hold inputs at the active level, release them, and keep an input active across reset, so that non-edges can be told apart from real events.

// File: rtl/psg_pkg.sv
package psg_pkg;

    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned SRC_SYNC = 0;
    localparam int unsigned SRC_SYSREF = 1;
    // bit i set = source i is active low
    localparam logic [NUM_SRC-1:0] SRC_ACT_LOW = 2'b01;

    typedef enum logic [1:0] {
        POL_FULL    = 2'd0,
        POL_DP_ONLY = 2'd1
    } policy_e;

    typedef struct packed {
        logic link;
        logic dp;
    } rst_req_t;

    typedef struct packed {
        logic keep_link;
        logic first_only;
    } cfg_t;

    function automatic policy_e pick_policy(cfg_t cfg, logic spent);
        if (cfg.keep_link)
            return POL_DP_ONLY;
        else if (cfg.first_only && spent)
            return POL_DP_ONLY;
        else
            return POL_FULL;
    endfunction

    function automatic rst_req_t expand_policy(policy_e pol, logic evt);
        rst_req_t r;
        r.dp   = evt;
        r.link = evt && (pol == POL_FULL);
        return r;
    endfunction

endpackage

// File: rtl/psg_edge_detect.sv
module psg_edge_detect #(
    parameter int unsigned N = psg_pkg::NUM_SRC,
    parameter logic [N-1:0] ACT_LOW = psg_pkg::SRC_ACT_LOW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] hit,
    output logic         any_hit
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic act_now;
        logic act_prev;

        always_comb begin
            act_now  = ACT_LOW[i] ? ~lvl[i]    : lvl[i];
            act_prev = ACT_LOW[i] ? ~prev_q[i] : prev_q[i];
            hit[i]   = act_now && !act_prev;
        end

        // capture the live level during reset so a level held across release is not an edge
        always_ff @(posedge clk) begin
            prev_q[i] <= lvl[i];
        end

        // R2: an edge needs an idle sample first, so it never repeats in back-to-back cycles
        a_r2_edge_not_level: assert property (@(posedge clk) disable iff (rst)
            hit[i] |=> !hit[i]);
    end

    assign any_hit = |hit;

endmodule

// File: rtl/psg_oneshot.sv
module psg_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic first_only,
    input  logic evt,
    output logic spent
);

    logic spent_q;

    always_ff @(posedge clk) begin
        if (rst)
            spent_q <= 1'b0;
        else if (!first_only)
            spent_q <= 1'b0;
        else if (evt)
            spent_q <= 1'b1;
    end

    assign spent = spent_q;

    // R6: leaving one-shot mode clears the spent state
    a_r6_clear_rearms: assert property (@(posedge clk) disable iff (rst)
        !first_only |=> !spent_q);

    // R4: the spent flag only rises from an event seen in one-shot mode
    a_r4_rise_from_event: assert property (@(posedge clk) disable iff (rst)
        $rose(spent_q) |-> $past(evt && first_only));

endmodule

// File: rtl/psg_pulse_out.sv
module psg_pulse_out (
    input  logic              clk,
    input  logic              rst,
    input  psg_pkg::rst_req_t req,
    output psg_pkg::rst_req_t pulse
);

    psg_pkg::rst_req_t pulse_q;

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= '0;
        else
            pulse_q <= req;
    end

    assign pulse = pulse_q;

    // R1: a link-domain reset is always paired with a datapath reset
    a_r1_link_implies_dp: assert property (@(posedge clk) disable iff (rst)
        pulse_q.link |-> pulse_q.dp);

endmodule

// File: rtl/psg_phase_reset_gate.sv
module psg_phase_reset_gate (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    input  logic sysref,
    input  logic cfg_keep_link,
    input  logic cfg_first_only,
    output logic link_rst_pulse,
    output logic dp_rst_pulse,
    output logic oneshot_spent
);
    import psg_pkg::*;

    logic [NUM_SRC-1:0] src_lvl;
    logic [NUM_SRC-1:0] src_hit;
    logic               evt;
    logic               spent;
    cfg_t               cfg;
    policy_e            pol;
    rst_req_t           req;
    rst_req_t           pulse;

    always_comb begin
        src_lvl             = '0;
        src_lvl[SRC_SYNC]   = sync_n;
        src_lvl[SRC_SYSREF] = sysref;
        cfg.keep_link       = cfg_keep_link;
        cfg.first_only      = cfg_first_only;
    end

    psg_edge_detect #(
        .N       (NUM_SRC),
        .ACT_LOW (SRC_ACT_LOW)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl     (src_lvl),
        .hit     (src_hit),
        .any_hit (evt)
    );

    psg_oneshot u_oneshot (
        .clk        (clk),
        .rst        (rst),
        .first_only (cfg_first_only),
        .evt        (evt),
        .spent      (spent)
    );

    always_comb begin
        pol = pick_policy(cfg, spent);
        req = expand_policy(pol, evt);
    end

    psg_pulse_out u_pulse (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .pulse (pulse)
    );

    assign link_rst_pulse = pulse.link;
    assign dp_rst_pulse   = pulse.dp;
    assign oneshot_spent  = spent;

    // R3, R7: the keep-link bit blocks every link-domain reset
    a_r3_keep_link_blocks: assert property (@(posedge clk) disable iff (rst)
        link_rst_pulse |-> !$past(cfg_keep_link));

    // R5: once the one-shot is used, link resets stop while the mode stays on
    a_r5_spent_dp_only: assert property (@(posedge clk) disable iff (rst)
        link_rst_pulse |-> !$past(cfg_first_only && spent));

    // R8: any datapath pulse traces back to an edge on some source
    a_r8_pulse_has_edge: assert property (@(posedge clk) disable iff (rst)
        dp_rst_pulse |-> $past(|src_hit));

endmodule

// File: tb/sim_psg_phase_reset_gate.sv
`timescale 1ns/1ps
module sim_psg_phase_reset_gate;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1;
    logic sysref = 1'b0;
    logic cfg_keep_link = 1'b0;
    logic cfg_first_only = 1'b0;
    logic link_rst_pulse, dp_rst_pulse, oneshot_spent;

    int n_run = 0;
    int n_fail = 0;
    logic m_spent = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    psg_phase_reset_gate u0 (
        .clk            (clk),
        .rst            (rst),
        .sync_n         (sync_n),
        .sysref         (sysref),
        .cfg_keep_link  (cfg_keep_link),
        .cfg_first_only (cfg_first_only),
        .link_rst_pulse (link_rst_pulse),
        .dp_rst_pulse   (dp_rst_pulse),
        .oneshot_spent  (oneshot_spent)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic el, input logic ed, input logic es);
        chk({tag, " link"}, link_rst_pulse, el);
        chk({tag, " dp"}, dp_rst_pulse, ed);
        chk({tag, " spent"}, oneshot_spent, es);
    endtask

    // one event from the chosen sources, checked against the arithmetic model
    task automatic fire(input string tag, input logic s, input logic r);
        logic exp_link;
        @(negedge clk);
        if (s) sync_n = 1'b0;
        if (r) sysref = 1'b1;
        exp_link = !cfg_keep_link && !(cfg_first_only && m_spent);
        m_spent  = cfg_first_only ? 1'b1 : 1'b0;
        @(negedge clk);
        chk_all(tag, exp_link, 1'b1, m_spent);
        sync_n = 1'b1;
        sysref = 1'b0;
        @(negedge clk);
        chk_all({tag, " after"}, 1'b0, 1'b0, m_spent);
    endtask

    task automatic set_cfg(input logic k, input logic f);
        @(negedge clk);
        cfg_keep_link  = k;
        cfg_first_only = f;
        if (!f) m_spent = 1'b0;
        @(negedge clk);
        chk("R6 spent after cfg", oneshot_spent, m_spent);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R9 in reset", 1'b0, 1'b0, 1'b0);
        // R9: sync_n held active across the release of reset
        sync_n = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R9 first cycle", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk_all("R9 held level", 1'b0, 1'b0, 1'b0);
        // R2: a rising sync_n is no event
        sync_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_all("R2 sync rise", 1'b0, 1'b0, 1'b0);

        // sweep: config x source pattern x three events (R1 R3 R4 R5 R7 R8)
        for (int c = 0; c < 4; c++) begin
            set_cfg(1'b0, 1'b0);
            set_cfg(c[1], c[0]);
            for (int p = 1; p < 4; p++) begin
                for (int e = 0; e < 3; e++) begin
                    case (c)
                        0: fire(p == 3 ? "R8 default" : "R1 default", p[0], p[1]);
                        1: fire(e == 0 && p == 1 ? "R4 first" : "R5 later", p[0], p[1]);
                        2: fire("R3 keep link", p[0], p[1]);
                        default: fire("R7 both bits", p[0], p[1]);
                    endcase
                end
            end
        end

        // R2: sysref held high then falling gives nothing
        set_cfg(1'b0, 1'b0);
        @(negedge clk); sysref = 1'b1;
        @(negedge clk);
        chk_all("R2 sysref edge", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk_all("R2 sysref held", 1'b0, 1'b0, 1'b0);
        sysref = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_all("R2 sysref fall", 1'b0, 1'b0, 1'b0);

        // R6: re-arm by toggling the one-shot bit
        set_cfg(1'b0, 1'b1);
        fire("R4 arm", 1'b1, 1'b0);
        fire("R5 spent", 1'b0, 1'b1);
        set_cfg(1'b0, 1'b0);
        fire("R6 default again", 1'b0, 1'b1);
        set_cfg(1'b0, 1'b1);
        fire("R6 rearmed", 1'b1, 1'b0);
        fire("R6 spent again", 1'b1, 1'b1);

        // R8: sync edge then sysref edge on the next cycle are two events
        set_cfg(1'b0, 1'b0);
        @(negedge clk); sync_n = 1'b0;
        @(negedge clk); sysref = 1'b1;
        chk_all("R8 first of pair", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk_all("R8 second of pair", 1'b1, 1'b1, 1'b0);
        sync_n = 1'b1; sysref = 1'b0;
        @(negedge clk);
        chk_all("R8 pair end", 1'b0, 1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule